// File: doc/BRIEF.md
# Paired Wide-Increment Event Counter Bank

A bank of six event counters, grouped as three even/odd pairs. Each counter has a 64-bit control word and a count register. Both are reached through one register port with a single address. On every clock, an enabled counter adds the 4-bit value on its increment lane to a 48-bit count. Event-routing logic outside the bank decodes the control words and drives the lanes.

Some events arrive at more than 15 per cycle. For these, an even counter can be fused with the odd counter directly above it. To fuse a pair, software first writes the odd partner's control word with the merge event code and its enable set. It then enables the even primary. From then on the pair adds an 8-bit value each cycle, made from the odd lane (high nibble) and the even lane (low nibble), to a 64-bit count. The low 48 bits of that count sit in the primary and the top 16 bits sit in the low bits of the partner's count. A read of the primary returns all 64 bits. A write to the primary sets only the low 48 bits, and the upper bits are written through the partner.

Top module: `evc_bank`

## Requirements
- R1: After reset every control word and every count reads zero, and no pair is fused.
- R2: A counter that is not fused and has control bit 22 set adds its 4-bit lane each cycle. The lane for counter i is lane_inc[4i+3:4i]. The 48-bit count wraps from 2^48-1 to a low value modulo 2^48. Counting starts in the cycle after the enabling write.
- R3: A counter with control bit 22 clear holds its count whatever its lane carries.
- R4: Pair (2k, 2k+1) fuses only on the cycle when the primary's enable bit goes from 0 to 1 while the partner's control word already holds all three of the following:
  - bits [7:0] = 0xFF;
  - bits [35:32] = 0xF;
  - bit 22 = 1.

  A partner set up after the primary was enabled does not fuse the pair until the primary is disabled and enabled again.
- R5: A fused pair adds {odd lane, even lane} each cycle to a 64-bit count. The carry out of bit 47 enters the upper 16-bit field in the same cycle, and the 64-bit value wraps to zero.
- R6: A read of a fused primary's count returns {partner count[15:0], primary count[47:0]}. A read of any other count returns its 48 bits zero-extended.
- R7: A write to a primary's count sets only its 48 low bits. A write to a partner's count sets its 48 bits, whose low 16 bits are the upper bits of a fused count.
- R8: A count write in the same cycle as an increment wins for the written register. A read returns the value from before that cycle's update.
- R9: A non-fused odd counter counts its own lane independently. An odd counter whose control word holds the merge code never counts its own lane.
- R10: A fused pair splits when the primary is disabled, or when the partner's control word loses the merge code or its enable bit. Both counters then behave as independent counters.
- R11: Register address = {counter index, select}, where select 0 is the control word and select 1 is the count. Control words read back exactly as written. Indices 6 and 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_inc | input | 24 | Per-counter 4-bit increment lanes, counter i at [4i+3:4i] |
| reg_addr | input | 4 | Register address {index, select} |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the addressed register (combinational) |

## Verification
A wrong fuse flag shows up on the first cycle in which both lanes of a pair are non-zero. A fused pair and a split pair then add different amounts, so the next read of the primary differs from the expected value straight away. A lost carry into the upper field appears only at the 2^48 boundary, so the counts are preloaded just below it through the write port. A wrong merge-latch condition shows only in the order in which the two control words are written, so both orders are driven and each is followed by a lane pattern that tells the two states apart.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int CTL_W   = 64;
  localparam int CNT_W   = 48;
  localparam int HI_W    = 16;
  localparam int LANE_W  = 4;
  localparam int VIEW_W  = CNT_W + HI_W;
  localparam int EN_BIT  = 22;
  localparam logic [11:0] FUSE_CODE = 12'hFFF;

  function automatic logic ctl_enabled(input logic [CTL_W-1:0] c);
    return c[EN_BIT];
  endfunction

  function automatic logic [11:0] ctl_event(input logic [CTL_W-1:0] c);
    return {c[35:32], c[7:0]};
  endfunction

  function automatic logic [CNT_W-1:0] narrow_add(input logic [CNT_W-1:0] c,
                                                  input logic [LANE_W-1:0] inc);
    return c + CNT_W'(inc);
  endfunction

  function automatic logic [VIEW_W-1:0] wide_add(input logic [HI_W-1:0] hi,
                                                 input logic [CNT_W-1:0] lo,
                                                 input logic [2*LANE_W-1:0] inc);
    return {hi, lo} + VIEW_W'(inc);
  endfunction
endpackage

// File: rtl/evc_addr_dec.sv
module evc_addr_dec #(
  parameter int NCNT = 6,
  parameter int AW   = 4
) (
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  output logic [NCNT-1:0] wr_ctl,
  output logic [NCNT-1:0] wr_cnt
);
  logic [AW-2:0] idx;
  logic          sel;
  assign idx = addr[AW-1:1];
  assign sel = addr[0];

  for (genvar i = 0; i < NCNT; i++) begin : g_strobe
    assign wr_ctl[i] = wr && (idx == (AW-1)'(i)) && !sel;
    assign wr_cnt[i] = wr && (idx == (AW-1)'(i)) &&  sel;
  end
endmodule

// File: rtl/evc_pair.sv
module evc_pair
  import evc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] lane_e,
  input  logic [LANE_W-1:0] lane_o,
  input  logic              wr_ctl_e,
  input  logic              wr_ctl_o,
  input  logic              wr_cnt_e,
  input  logic              wr_cnt_o,
  input  logic [CTL_W-1:0]  wdata,
  output logic [CTL_W-1:0]  ctl_e_rd,
  output logic [CTL_W-1:0]  ctl_o_rd,
  output logic [VIEW_W-1:0] view_e,
  output logic [VIEW_W-1:0] view_o
);
  logic [CTL_W-1:0]  ctl_e_q, ctl_o_q, ctl_e_nx, ctl_o_nx;
  logic [CNT_W-1:0]  cnt_e_q, cnt_o_q, cnt_e_nx, cnt_o_nx;
  logic              fused_q, fused_nx;

  // named internal events
  logic en_e, en_o, o_fuse_code, partner_ready;
  logic en_e_nx, partner_ready_nx, prim_rise, odd_solo;
  logic [VIEW_W-1:0] wide_sum;
  logic [CNT_W-1:0]  narrow_e, narrow_o;

  assign en_e          = ctl_enabled(ctl_e_q);
  assign en_o          = ctl_enabled(ctl_o_q);
  assign o_fuse_code   = (ctl_event(ctl_o_q) == FUSE_CODE);
  assign partner_ready = en_o && o_fuse_code;

  assign ctl_e_nx         = wr_ctl_e ? wdata : ctl_e_q;
  assign ctl_o_nx         = wr_ctl_o ? wdata : ctl_o_q;
  assign en_e_nx          = ctl_enabled(ctl_e_nx);
  assign partner_ready_nx = ctl_enabled(ctl_o_nx) && (ctl_event(ctl_o_nx) == FUSE_CODE);
  assign prim_rise        = en_e_nx && !en_e;

  always_comb begin
    if (!(en_e_nx && partner_ready_nx)) fused_nx = 1'b0;
    else if (prim_rise)                 fused_nx = partner_ready;
    else                                fused_nx = fused_q;
  end

  assign wide_sum = wide_add(cnt_o_q[HI_W-1:0], cnt_e_q, {lane_o, lane_e});
  assign narrow_e = narrow_add(cnt_e_q, lane_e);
  assign narrow_o = narrow_add(cnt_o_q, lane_o);
  assign odd_solo = en_o && !o_fuse_code && !fused_q;

  always_comb begin
    cnt_e_nx = cnt_e_q;
    cnt_o_nx = cnt_o_q;
    if (fused_q) begin
      cnt_e_nx             = wide_sum[CNT_W-1:0];
      cnt_o_nx[HI_W-1:0]   = wide_sum[VIEW_W-1:CNT_W];
    end else begin
      if (en_e)     cnt_e_nx = narrow_e;
      if (odd_solo) cnt_o_nx = narrow_o;
    end
    if (wr_cnt_e) cnt_e_nx = wdata[CNT_W-1:0];
    if (wr_cnt_o) cnt_o_nx = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_e_q <= '0;
      ctl_o_q <= '0;
      cnt_e_q <= '0;
      cnt_o_q <= '0;
      fused_q <= 1'b0;
    end else begin
      ctl_e_q <= ctl_e_nx;
      ctl_o_q <= ctl_o_nx;
      cnt_e_q <= cnt_e_nx;
      cnt_o_q <= cnt_o_nx;
      fused_q <= fused_nx;
    end
  end

  assign ctl_e_rd = ctl_e_q;
  assign ctl_o_rd = ctl_o_q;
  assign view_e   = fused_q ? {cnt_o_q[HI_W-1:0], cnt_e_q} : {{HI_W{1'b0}}, cnt_e_q};
  assign view_o   = {{HI_W{1'b0}}, cnt_o_q};

  // R4
  fuse_partner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fused_q |-> (en_e && partner_ready));
  // R4
  fuse_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fused_q) |-> $rose(en_e));
  // R5
  wide_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fused_q && !wr_cnt_e && !wr_cnt_o && !wr_ctl_e && !wr_ctl_o)
    |=> view_e == $past(view_e) + VIEW_W'($past({lane_o, lane_e})));
  // R2
  narrow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fused_q && en_e && !wr_cnt_e) |=> cnt_e_q == $past(cnt_e_q) + CNT_W'($past(lane_e)));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fused_q && !en_e && !wr_cnt_e) |=> $stable(cnt_e_q));
  // R8
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_e |=> cnt_e_q == $past(wdata[CNT_W-1:0]));
  // R9
  odd_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fused_q && o_fuse_code && !wr_cnt_o) |=> $stable(cnt_o_q));
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter  int NPAIR = 3,
  localparam int NCNT  = 2 * NPAIR,
  localparam int AW    = $clog2(2 * NCNT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCNT*LANE_W-1:0] lane_inc,
  input  logic [AW-1:0]          reg_addr,
  input  logic                   reg_wr,
  input  logic [CTL_W-1:0]       reg_wdata,
  output logic [CTL_W-1:0]       reg_rdata
);
  localparam int NSLOT = 1 << (AW - 1);

  logic [NCNT-1:0]   wr_ctl, wr_cnt;
  logic [CTL_W-1:0]  ctl_v [NSLOT];
  logic [VIEW_W-1:0] cnt_v [NSLOT];

  evc_addr_dec #(.NCNT(NCNT), .AW(AW)) u_dec (
    .addr(reg_addr), .wr(reg_wr), .wr_ctl(wr_ctl), .wr_cnt(wr_cnt)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    evc_pair u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_e   (lane_inc[(2*p)*LANE_W +: LANE_W]),
      .lane_o   (lane_inc[(2*p+1)*LANE_W +: LANE_W]),
      .wr_ctl_e (wr_ctl[2*p]),
      .wr_ctl_o (wr_ctl[2*p+1]),
      .wr_cnt_e (wr_cnt[2*p]),
      .wr_cnt_o (wr_cnt[2*p+1]),
      .wdata    (reg_wdata),
      .ctl_e_rd (ctl_v[2*p]),
      .ctl_o_rd (ctl_v[2*p+1]),
      .view_e   (cnt_v[2*p]),
      .view_o   (cnt_v[2*p+1])
    );
  end

  for (genvar s = NCNT; s < NSLOT; s++) begin : g_empty
    assign ctl_v[s] = '0;
    assign cnt_v[s] = '0;
  end

  assign reg_rdata = reg_addr[0] ? cnt_v[reg_addr[AW-1:1]] : ctl_v[reg_addr[AW-1:1]];

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ctl, wr_cnt}));
  // R11
  strobe_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |-> ({wr_ctl, wr_cnt} == '0));
endmodule

// File: tb/sim_evc_bank.sv
module sim_evc_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] EN      = 64'h0000_0000_0040_0000;
  localparam logic [63:0] FUSECTL = 64'h0000_000F_0040_00FF;

  // {lane value applied to every lane, expected count of counter 3 after that cycle}
  localparam logic [11:0] VEC [6] = '{
    {4'd1, 8'd1}, {4'd15, 8'd16}, {4'd0, 8'd16},
    {4'd7, 8'd23}, {4'd15, 8'd38}, {4'd3, 8'd41}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] lane_inc = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  int n_chk = 0;
  int n_bad = 0;

  evc_bank u0 (.clk(clk), .rst_n(rst_n), .lane_inc(lane_inc), .reg_addr(reg_addr),
               .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] lane(int idx, logic [3:0] v);
    logic [23:0] r = '0;
    r[4*idx +: 4] = v;
    return r;
  endfunction

  // one clock with the given lanes and optional write
  task automatic step(logic [23:0] l, logic w, logic [3:0] a, logic [63:0] d);
    @(negedge clk);
    lane_inc = l; reg_wr = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
  endtask

  task automatic wr(int idx, logic sel, logic [63:0] d);
    step('0, 1'b1, {3'(idx), sel}, d);
  endtask

  task automatic rd_chk(string req, int idx, logic sel, logic [63:0] exp);
    @(negedge clk);
    lane_inc = '0; reg_wr = 1'b0; reg_addr = {3'(idx), sel};
    #1 check(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd_chk("R1", i, 1'b0, 64'h0);
      rd_chk("R1", i, 1'b1, 64'h0);
    end

    // R11 control readback and unused indices
    wr(1, 1'b0, 64'hDEAD_BEEF_0012_3456);
    rd_chk("R11", 1, 1'b0, 64'hDEAD_BEEF_0012_3456);
    wr(1, 1'b0, 64'h0);
    wr(6, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(7, 1'b1, 64'h1234);
    rd_chk("R11", 6, 1'b0, 64'h0);
    rd_chk("R11", 7, 1'b1, 64'h0);
    rd_chk("R11", 1, 1'b0, 64'h0);

    // R2 / R3 table: counter 3 enabled, counter 2 disabled, all lanes driven
    wr(3, 1'b0, EN);
    for (int k = 0; k < 6; k++) begin
      step({6{VEC[k][11:8]}}, 1'b0, '0, '0);
      rd_chk("R2", 3, 1'b1, {56'h0, VEC[k][7:0]});
    end
    rd_chk("R3", 2, 1'b1, 64'h0);
    wr(3, 1'b0, 64'h0);

    // R2 48-bit wrap on counter 0
    wr(0, 1'b1, 64'h0000_FFFF_FFFF_FFFE);
    wr(0, 1'b0, EN);
    step(lane(0, 4'd3), 1'b0, '0, '0);
    rd_chk("R2", 0, 1'b1, 64'h1);
    wr(0, 1'b0, 64'h0);

    // R9 independent odd counter 5
    wr(5, 1'b0, EN | 64'h0C);
    step(lane(5, 4'd9) | lane(4, 4'd6), 1'b0, '0, '0);
    rd_chk("R9", 5, 1'b1, 64'd9);
    rd_chk("R3", 4, 1'b1, 64'h0);
    wr(5, 1'b0, 64'h0);
    wr(5, 1'b1, 64'h0);

    // R4/R5/R6 fuse pair 2/3 in the correct order
    wr(3, 1'b0, FUSECTL);
    wr(2, 1'b1, 64'h0000_FFFF_FFFF_FFF0);
    wr(3, 1'b1, 64'h5);
    wr(2, 1'b0, EN | 64'h03);
    step(lane(2, 4'h4) | lane(3, 4'h2), 1'b0, '0, '0);
    rd_chk("R5", 2, 1'b1, 64'h0006_0000_0000_0014);
    rd_chk("R6", 3, 1'b1, 64'h6);

    // R5 64-bit wrap to zero
    wr(3, 1'b1, 64'hFFFF);
    wr(2, 1'b1, 64'h0000_FFFF_FFFF_FFFF);
    step(lane(2, 4'h1), 1'b0, '0, '0);
    rd_chk("R5", 2, 1'b1, 64'h0);

    // R7 split writes
    wr(2, 1'b1, 64'hABCD_0000_0000_0011);
    rd_chk("R7", 2, 1'b1, 64'h0000_0000_0000_0011);
    wr(3, 1'b1, 64'h1234);
    rd_chk("R7", 2, 1'b1, 64'h1234_0000_0000_0011);

    // R8 write beats increment; read shows the old value
    @(negedge clk);
    lane_inc = lane(2, 4'h4) | lane(3, 4'h2); reg_wr = 1'b1;
    reg_addr = {3'd2, 1'b1}; reg_wdata = 64'h100;
    #1 check("R8", reg_rdata, 64'h1234_0000_0000_0011);
    @(posedge clk);
    rd_chk("R8", 2, 1'b1, 64'h1234_0000_0000_0100);

    // R10 disabling the primary splits the pair
    wr(2, 1'b0, 64'h0);
    rd_chk("R10", 2, 1'b1, 64'h0000_0000_0000_0100);
    wr(3, 1'b0, 64'h0);

    // R4 wrong order: primary 4 first, partner 5 later
    wr(4, 1'b1, 64'h0);
    wr(4, 1'b0, EN);
    wr(5, 1'b0, FUSECTL);
    step(lane(4, 4'd1) | lane(5, 4'd1), 1'b0, '0, '0);
    rd_chk("R4", 4, 1'b1, 64'd1);
    rd_chk("R9", 5, 1'b1, 64'd0);
    // re-enable primary: pair now fuses
    wr(4, 1'b0, 64'h0);
    wr(4, 1'b0, EN);
    step(lane(5, 4'd1), 1'b0, '0, '0);
    rd_chk("R4", 4, 1'b1, 64'd17);

    // R10 partner loses its setup: independent again
    wr(5, 1'b0, 64'h0);
    step(lane(4, 4'd1) | lane(5, 4'd1), 1'b0, '0, '0);
    rd_chk("R10", 4, 1'b1, 64'd18);
    rd_chk("R10", 5, 1'b1, 64'd0);

    finish_run();
  end
endmodule